// File: doc/BRIEF.md
# Three-Level Pulse-Pair Line Encoder

This block turns a stream of parallel words into a single-wire line code. The code carries both the data and a bit-rate timing reference. It is clocked by a fast symbol clock that runs at twice the serial bit rate. An internal divide-by-sixteen phase counter marks one load point per word period. At that point the block offers `word_ready` and takes a word on a valid/ready handshake. It then sends the word's bits over the next sixteen symbol cycles, starting with the most significant bit.

Each bit is split into two half-bit symbols of opposite polarity. A one is sent as LOW then HIGH, and a zero as HIGH then LOW. Every bit therefore contains one rising or falling excursion pair, from which a receiver can recover the bit clock. Because each pair has one LOW and one HIGH, the line average sits at the middle level for any data pattern. The middle level itself appears only when no data is on the line: after reset, or for a whole word period when no word was offered at the load point.

The controller is a three-state machine:
- **ST_IDLE**: entered by reset; the line sits at MID.
- **ST_SEND**: the line carries the captured word.
- **ST_STARVE**: the line sits at MID and the underrun flag is raised.

Transitions happen only at the load point:
- **IDLE→SEND**, **SEND→SEND** and **STARVE→SEND** on an accepted word.
- **IDLE→STARVE**, **SEND→STARVE** and **STARVE→STARVE** when no word is offered.
- Reset returns the machine from any state to ST_IDLE.

Top module: `tri_level_line_encoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after the clock edge at which it was sampled high, `line_sym` is MID (2'b01), `underrun` is 0 and `word_ready` is 0. After `rst` falls, `word_ready` first rises in the 15th cycle after the last reset edge.
- R2: `word_ready` is high for exactly one symbol cycle out of every 16 (the load point, phase count 15) and low in the other 15.
- R3: A word is accepted at a clock edge where `word_valid` and `word_ready` are both high. Over the next 16 cycles its bits go out most significant first, two symbols per bit: bit 7 in cycles 0–1 after acceptance, down to bit 0 in cycles 14–15.
- R4: A data bit of 1 is sent as LOW (2'b00) in its first half-symbol, then HIGH (2'b10) in its second.
- R5: A data bit of 0 is sent as HIGH (2'b10) in its first half-symbol, then LOW (2'b00) in its second.
- R6: Words accepted at consecutive load points are sent back to back, with no MID symbol between them.
- R7: If `word_valid` is low at a load point, `line_sym` is MID (2'b01) and `underrun` is 1 for each of the following 16 cycles. `underrun` is 0 during any word period that carries data.
- R8: `word_valid` and `word_data` presented outside the load point have no effect on `line_sym` or `underrun`.
- R9: Each transmitted word has exactly as many LOW symbols as HIGH symbols (eight of each). The code 2'b11 never appears on `line_sym`.
- R10: `rst` asserted in the middle of a word aborts it: the next cycle shows MID, and the phase count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, twice the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| word_data | input | WORD_W (8) | Parallel word to send |
| word_valid | input | 1 | A word is offered on `word_data` |
| word_ready | output | 1 | Load point; the offered word is taken at this edge |
| line_sym | output | 2 | Line symbol: 00 LOW, 01 MID, 10 HIGH |
| underrun | output | 1 | High for a whole word period sent as MID because no word was offered |

## Verification
The bench aims at the load-point edge from several sides:
- **Back-to-back words:** a design that captured one cycle late would drop or duplicate a bit at word boundaries.
- **Starved periods mixed with live ones:** a wrongly held underrun flag, or leftover bits leaking into a MID period, would show up here.
- **Junk offered off the load point:** a design that loaded whenever `word_valid` was high would corrupt the word in flight.

Polarity and order are checked symbol by symbol, so a swapped pair order or a least-significant-first shift fails at once. A reset dropped into the middle of a word checks that both the phase count and the line restart cleanly.

// File: rtl/tle_pkg.sv
package tle_pkg;
    typedef enum logic [1:0] {
        SYM_LOW  = 2'b00,
        SYM_MID  = 2'b01,
        SYM_HIGH = 2'b10
    } line_sym_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SEND   = 2'b01,
        ST_STARVE = 2'b10
    } enc_state_t;
endpackage

// File: rtl/tle_phase_div.sv
module tle_phase_div #(
    parameter int SYM_PER_WORD = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    output logic [$clog2(SYM_PER_WORD)-1:0] phase,
    output logic                            second_half,
    output logic                            load_pt
);
    localparam int CNT_W = $clog2(SYM_PER_WORD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_PER_WORD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign second_half = phase[0];
    assign load_pt     = (phase == LAST) && !rst;

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));
    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/tle_word_shifter.sv
module tle_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
        end
    end

    assign cur_bit = sreg[WORD_W-1];

    // R3
    shift_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_bit == $past(din[WORD_W-1])));
endmodule

// File: rtl/tle_symbol_map.sv
module tle_symbol_map
    import tle_pkg::*;
(
    input  logic      active,
    input  logic      data_bit,
    input  logic      second_half,
    output line_sym_t sym
);
    always_comb begin
        if (!active) begin
            sym = SYM_MID;
        end else if (data_bit ^ second_half) begin
            sym = SYM_LOW;
        end else begin
            sym = SYM_HIGH;
        end
    end
endmodule

// File: rtl/tri_level_line_encoder.sv
module tri_level_line_encoder
    import tle_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic [1:0]        line_sym,
    output logic              underrun
);
    localparam int SYM_PER_WORD = 2 * WORD_W;
    localparam int CNT_W        = $clog2(SYM_PER_WORD);

    enc_state_t       st_q, st_d;
    logic [CNT_W-1:0] phase;
    logic             second_half;
    logic             load_pt;
    logic             accept;
    logic             cur_bit;
    logic             active;
    line_sym_t        sym;

    tle_phase_div #(.SYM_PER_WORD(SYM_PER_WORD)) u_div (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .second_half (second_half),
        .load_pt     (load_pt)
    );

    assign accept = load_pt && word_valid;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (load_pt) st_d = word_valid ? ST_SEND : ST_STARVE;
            ST_SEND:   if (load_pt) st_d = word_valid ? ST_SEND : ST_STARVE;
            ST_STARVE: if (load_pt) st_d = word_valid ? ST_SEND : ST_STARVE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    tle_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .shift   ((st_q == ST_SEND) && second_half),
        .din     (word_data),
        .cur_bit (cur_bit)
    );

    always_comb begin
        active     = 1'b0;
        underrun   = 1'b0;
        word_ready = load_pt;
        unique case (st_q)
            ST_IDLE:   begin active = 1'b0; underrun = 1'b0; end
            ST_SEND:   begin active = 1'b1; underrun = 1'b0; end
            ST_STARVE: begin active = 1'b0; underrun = 1'b1; end
            default:   begin active = 1'b0; underrun = 1'b0; end
        endcase
    end

    tle_symbol_map u_map (
        .active      (active),
        .data_bit    (cur_bit),
        .second_half (second_half),
        .sym         (sym)
    );

    assign line_sym = sym;

    // R9
    no_illegal_sym_chk: assert property (@(posedge clk) disable iff (rst)
        line_sym != 2'b11);
    // R9
    pair_balance_chk: assert property (@(posedge clk) disable iff (rst)
        (active && second_half) |-> (line_sym != SYM_MID && line_sym != $past(line_sym)));
    // R7
    starve_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (word_ready && !word_valid) |=> (underrun && line_sym == SYM_MID));
    // R3
    accept_send_chk: assert property (@(posedge clk) disable iff (rst)
        (word_ready && word_valid) |=> (!underrun && line_sym != SYM_MID));
    // R1
    reset_mid_chk: assert property (@(posedge clk)
        rst |=> (line_sym == SYM_MID && !underrun));
endmodule

// File: tb/tri_level_line_encoder_tb.sv
module tri_level_line_encoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MAX_CYC    = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] word_data = '0;
    logic         word_valid = 1'b0;
    logic         word_ready;
    logic [1:0]   line_sym;
    logic         underrun;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    tri_level_line_encoder #(.WORD_W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .line_sym   (line_sym),
        .underrun   (underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, MAX_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [1:0] exp_sym(input logic give, input logic [W-1:0] d, input int i);
        logic b;
        if (!give) return 2'b01;
        b = d[W-1-(i/2)];
        if (i % 2 == 0) return b ? 2'b00 : 2'b10;
        return b ? 2'b10 : 2'b00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge where word_ready is high; returns at the next such negedge.
    task automatic do_period(input logic give, input logic [W-1:0] d, input logic noise);
        int n_low;
        int n_high;
        n_low  = 0;
        n_high = 0;
        chk("R2 load point", {7'd0, word_ready}, 8'd1);
        word_valid = give;
        word_data  = d;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            // R3 R4 R5 R6 R8: symbol order and polarity
            chk(give ? "R3/R4/R5 symbol" : "R7 starve symbol",
                {6'd0, line_sym}, {6'd0, exp_sym(give, d, i)});
            chk("R7 underrun", {7'd0, underrun}, {7'd0, !give});
            chk("R2 ready", {7'd0, word_ready}, {7'd0, (i == 15)});
            if (line_sym == 2'b00) n_low++;
            if (line_sym == 2'b10) n_high++;
            if (i < 15) begin
                // R8: junk offered off the load point
                word_valid = noise ? 1'($urandom) : 1'b0;
                word_data  = W'($urandom);
                @(negedge clk);
            end else begin
                word_valid = 1'b0;
            end
        end
        if (give) begin
            chk("R9 balance", 8'(n_low), 8'(n_high));
            chk("R9 count", 8'(n_low), 8'(W));
        end
    endtask

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset sym", {6'd0, line_sym}, 8'h01);
        chk("R1 reset underrun", {7'd0, underrun}, 8'd0);
        chk("R1 reset ready", {7'd0, word_ready}, 8'd0);
        rst = 1'b0;
        for (int k = 1; k < 15; k++) begin
            @(negedge clk);
            chk("R1 idle ready", {7'd0, word_ready}, 8'd0);
            chk("R1 idle sym", {6'd0, line_sym}, 8'h01);
        end
        @(negedge clk);
        chk("R1 first load point", {7'd0, word_ready}, 8'd1);

        // directed corners: R4 all ones, R5 all zeros, R6 back to back
        do_period(1'b1, 8'hFF, 1'b0);
        do_period(1'b1, 8'h00, 1'b0);
        do_period(1'b1, 8'hA5, 1'b1);
        // R7 starve then resume
        do_period(1'b0, 8'h00, 1'b1);
        do_period(1'b0, 8'h00, 1'b0);
        do_period(1'b1, 8'h81, 1'b1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            do_period(($urandom % 5) != 0, W'($urandom), 1'($urandom));
        end

        // R10: reset mid-word
        word_valid = 1'b1;
        word_data  = 8'h3C;
        @(negedge clk);
        word_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 abort sym", {6'd0, line_sym}, 8'h01);
        chk("R10 abort underrun", {7'd0, underrun}, 8'd0);
        chk("R10 abort ready", {7'd0, word_ready}, 8'd0);
        rst = 1'b0;
        for (int k = 1; k < 15; k++) begin
            @(negedge clk);
            chk("R10 restart ready", {7'd0, word_ready}, 8'd0);
        end
        @(negedge clk);
        chk("R10 restart load point", {7'd0, word_ready}, 8'd1);
        do_period(1'b1, 8'h5A, 1'b1);
        do_period(1'b1, 8'h01, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule